// File: doc/BRIEF.md
# Saturating Fixed-Point ALU with Sticky Status

This block is the integer arithmetic-logic stage of a signal-processing core. Each accepted operation takes two 32-bit two's-complement operands and an operation code, and one clock edge later presents the registered result together with a write-enable for the register file and a fresh set of status flags. When the saturation mode input is high, an add or subtract whose true value does not fit is clamped to the largest positive or most negative word instead of wrapping around. The overflow flag is still raised in that case.

Next to the per-operation status word sits a small sticky register. Once an operation reports overflow, the sticky overflow bit stays set through any number of later operations. Only the sticky-clear strobe resets it. A compare runs the subtract path for its flags but never asks for a register write. Two operation codes are reserved and leave every output untouched.

Top module: `satalu_top`

## Requirements
- R1: While `rst_n` is low, `result` is 0, `result_we` is 0, `status` is 0 and `sticky` is 0.
- R2: `op_code` selects the operation: 0 add, 1 subtract (a minus b), 2 compare, 3 AND, 4 OR, 5 XOR. An accepted operation (`op_valid` high at a rising edge) shows its result on `result`, with `result_we` high, after that edge. With `sat_en` low, signed overflow wraps modulo 2^32.
- R3: With `sat_en` high, an add or subtract that overflows produces 0x7FFFFFFF when the true value is positive and 0x80000000 when it is negative. The overflow flag is still set.
- R4: `status` bit 0 is zero (final result is 0), bit 1 is negative (result bit 31), bit 2 is signed overflow, bit 3 is carry, and bit 4 is invalid. Carry is the carry-out for add and the no-borrow (a >= b unsigned) for subtract and compare. Logic operations clear carry and overflow. Invalid is always 0.
- R5: A compare updates `status` from a minus b, leaves `result` unchanged and keeps `result_we` low.
- R6: `status` describes only the most recent accepted operation. On a cycle with `op_valid` low, `status` and `result` hold and `result_we` is 0.
- R7: `sticky` bit 0 is set by any accepted operation that raises overflow, and stays set until `sticky_clr` is high at a rising edge. `sticky` bit 1 follows the invalid flag in the same way.
- R8: When `sticky_clr` coincides with an overflowing operation, `sticky` ends up 0. The operation's `result` and `status` are still produced.
- R9: Op codes 6 and 7 are reserved. They change neither `result`, `status` nor `sticky`, and keep `result_we` low.
- R10: Adding 0xFFFFFFFF and 0x00000001 gives result 0 with zero=1, negative=0, overflow=0, carry=1, invalid=0, and sticky overflow stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation presented this cycle |
| op_code | input | 3 | Operation select (see R2) |
| sat_en | input | 1 | Saturation mode enable |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sticky_clr | input | 1 | Clears the sticky register |
| result | output | 32 | Registered result of the last writing operation |
| result_we | output | 1 | Register-file write enable, one cycle |
| status | output | 5 | {invalid, carry, overflow, negative, zero} |
| sticky | output | 2 | {invalid sticky, overflow sticky} |

## Verification
Every output is due one rising edge after the operation or clear that causes it: `result`, `result_we`, `status` and `sticky` are all registered once and have no further delay. The bench drives each operation on a falling edge and lets one rising edge pass. It reads the outputs on the following falling edge, before any later input is clocked in. A vector table covers wrap, saturation, carry, borrow and compare cases. Directed steps then check idle hold, clear priority and the reserved codes at that same half-cycle offset.

// File: rtl/satalu_pkg.sv
package satalu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CMP  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic inv;
        logic carry;
        logic ovf;
        logic neg;
        logic zero;
    } alu_stat_t;

    localparam int STAT_W   = $bits(alu_stat_t);
    localparam int STICKY_W = 2;

endpackage

// File: rtl/satalu_arith.sv
module satalu_arith
    import satalu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op_i,
    input  logic           sat_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   res_o,
    output alu_stat_t      stat_o,
    output logic           legal_o,
    output logic           wr_o
);

    localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

    logic           is_sub;
    logic [W-1:0]   b_eff;
    logic [W:0]     ext_sum;
    logic [W-1:0]   raw_sum;
    logic           arith_ovf;

    always_comb begin
        is_sub    = (op_i == OP_SUB) || (op_i == OP_CMP);
        b_eff     = is_sub ? ~b_i : b_i;
        ext_sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
        raw_sum   = ext_sum[W-1:0];
        arith_ovf = (a_i[W-1] == b_eff[W-1]) && (raw_sum[W-1] != a_i[W-1]);
    end

    always_comb begin
        res_o          = '0;
        legal_o        = 1'b1;
        stat_o.carry   = 1'b0;
        stat_o.ovf     = 1'b0;
        stat_o.inv     = 1'b0;
        unique case (op_i)
            OP_ADD, OP_SUB, OP_CMP: begin
                stat_o.carry = ext_sum[W];
                stat_o.ovf   = arith_ovf;
                if (arith_ovf && sat_i)
                    res_o = a_i[W-1] ? SAT_MIN : SAT_MAX;
                else
                    res_o = raw_sum;
            end
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            default: legal_o = 1'b0;
        endcase
        stat_o.zero = (res_o == '0);
        stat_o.neg  = res_o[W-1];
        wr_o        = legal_o && (op_i != OP_CMP);
    end

endmodule

// File: rtl/satalu_sticky.sv
module satalu_sticky #(
    parameter int N = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [N-1:0]  set_i,
    output logic [N-1:0]  q_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q_o[g] <= 1'b0;
            else if (clr_i)
                q_o[g] <= 1'b0;
            else if (set_i[g])
                q_o[g] <= 1'b1;
        end
    end

    // R8: a clear wins over any set on the same edge
    p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (q_o == '0));

    // R7: a set bit never drops without a clear
    p_no_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((q_o & $past(q_o)) == $past(q_o)));

    // R7: a set request without clear lands in the register
    p_set_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && (set_i != '0)) |=> ((q_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/satalu_top.sv
module satalu_top
    import satalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [OP_W-1:0]      op_code,
    input  logic                 sat_en,
    input  logic [W-1:0]         opnd_a,
    input  logic [W-1:0]         opnd_b,
    input  logic                 sticky_clr,
    output logic [W-1:0]         result,
    output logic                 result_we,
    output logic [STAT_W-1:0]    status,
    output logic [STICKY_W-1:0]  sticky
);

    localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

    alu_op_e        op_sel;
    logic [W-1:0]   core_res;
    alu_stat_t      core_stat;
    logic           core_legal;
    logic           core_wr;
    logic           accept;
    logic [STICKY_W-1:0] sticky_set;

    assign op_sel = alu_op_e'(op_code);
    assign accept = op_valid && core_legal;

    satalu_arith #(.W(W)) u_arith (
        .op_i    (op_sel),
        .sat_i   (sat_en),
        .a_i     (opnd_a),
        .b_i     (opnd_b),
        .res_o   (core_res),
        .stat_o  (core_stat),
        .legal_o (core_legal),
        .wr_o    (core_wr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            result_we <= 1'b0;
            status    <= '0;
        end else begin
            result_we <= accept && core_wr;
            if (accept) begin
                status <= core_stat;
                if (core_wr)
                    result <= core_res;
            end
        end
    end

    assign sticky_set = {accept && core_stat.inv, accept && core_stat.ovf};

    satalu_sticky #(.N(STICKY_W)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (sticky_clr),
        .set_i (sticky_set),
        .q_o   (sticky)
    );

    // R5: compare never writes and never moves the result
    p_cmp_nowr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CMP) |=> (!result_we && $stable(result)));

    // R6: idle cycles hold status and result
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(status) && $stable(result) && !result_we));

    // R9: reserved codes change nothing
    p_rsv_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code[2:1] == 2'b11) |=> ($stable(status) && $stable(result) && !result_we));

    // R3: saturated overflow lands on an extreme word with overflow flagged
    p_sat_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && sat_en && core_stat.ovf && (op_code == OP_ADD || op_code == OP_SUB))
        |=> ((result == SAT_MAX || result == SAT_MIN) && status[2]));

    // R4: invalid never raised for integer work
    p_inv_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !status[4]);

endmodule

// File: tb/sim_satalu_top.sv
`timescale 1ns/100ps
module sim_satalu_top;

    localparam int W  = 32;
    localparam int NV = 14;

    // {op[3], sat[1], a[32], b[32], exp_res[32], exp_stat[5], exp_we[1]}
    localparam logic [105:0] VEC [0:NV-1] = '{
        {3'd0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 5'b01001, 1'b1},
        {3'd0, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 5'b00110, 1'b1},
        {3'd0, 1'b1, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 5'b00100, 1'b1},
        {3'd0, 1'b1, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 5'b01110, 1'b1},
        {3'd1, 1'b0, 32'h00000005, 32'h00000003, 32'h00000002, 5'b01000, 1'b1},
        {3'd1, 1'b0, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 5'b00010, 1'b1},
        {3'd1, 1'b1, 32'h80000000, 32'h00000001, 32'h80000000, 5'b01110, 1'b1},
        {3'd1, 1'b0, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 5'b01100, 1'b1},
        {3'd2, 1'b0, 32'h00000007, 32'h00000007, 32'h7FFFFFFF, 5'b01001, 1'b0},
        {3'd3, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 5'b00010, 1'b1},
        {3'd4, 1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 5'b00001, 1'b1},
        {3'd5, 1'b1, 32'hAAAAAAAA, 32'h55555555, 32'hFFFFFFFF, 5'b00010, 1'b1},
        {3'd2, 1'b0, 32'h00000003, 32'h00000005, 32'hFFFFFFFF, 5'b00010, 1'b0},
        {3'd1, 1'b1, 32'h7FFFFFFF, 32'h80000000, 32'h7FFFFFFF, 5'b00100, 1'b1}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           op_valid = 1'b0;
    logic [2:0]     op_code = '0;
    logic           sat_en = 1'b0;
    logic [W-1:0]   opnd_a = '0;
    logic [W-1:0]   opnd_b = '0;
    logic           sticky_clr = 1'b0;
    logic [W-1:0]   result;
    logic           result_we;
    logic [4:0]     status;
    logic [1:0]     sticky;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    satalu_top #(.W(W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .sat_en     (sat_en),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .sticky_clr (sticky_clr),
        .result     (result),
        .result_we  (result_we),
        .status     (status),
        .sticky     (sticky)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic sat, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic clr);
        @(negedge clk);
        op_valid   = 1'b1;
        op_code    = op;
        sat_en     = sat;
        opnd_a     = a;
        opnd_b     = b;
        sticky_clr = clr;
        @(posedge clk);
        @(negedge clk);
        op_valid   = 1'b0;
        sticky_clr = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        sticky_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sticky_clr = 1'b0;
    endtask

    function automatic string vec_req(input int i);
        case (i)
            0:        return "R10";
            2, 3, 6:  return "R3";
            8, 12:    return "R5";
            4, 5, 13: return "R4";
            default:  return "R2";
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(result == '0,     "R1", "reset result", result, '0);
        check(result_we == 1'b0, "R1", "reset we", {31'b0, result_we}, '0);
        check(status == '0,     "R1", "reset status", {27'b0, status}, '0);
        check(sticky == '0,     "R1", "reset sticky", {30'b0, sticky}, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][105:103], VEC[i][102], VEC[i][101:70], VEC[i][69:38], 1'b0);
            check(result == VEC[i][37:6], vec_req(i), "result", result, VEC[i][37:6]);
            check(status == VEC[i][5:1], "R4", "status", {27'b0, status}, {27'b0, VEC[i][5:1]});
            check(result_we == VEC[i][0], vec_req(i), "we", {31'b0, result_we}, {31'b0, VEC[i][0]});
            if (i == 0)
                check(sticky[0] == 1'b0, "R10", "sticky ovf", {30'b0, sticky}, '0);
        end

        check(sticky == 2'b01, "R7", "sticky after overflows", {30'b0, sticky}, 32'd1);

        // R6: idle cycle holds
        @(negedge clk);
        check(status == 5'b00100, "R6", "idle status", {27'b0, status}, 32'h4);
        check(result == 32'h7FFFFFFF, "R6", "idle result", result, 32'h7FFFFFFF);
        check(result_we == 1'b0, "R6", "idle we", {31'b0, result_we}, '0);

        // R7: clear alone
        do_clear();
        check(sticky == 2'b00, "R7", "sticky after clear", {30'b0, sticky}, '0);
        check(status == 5'b00100, "R6", "status across clear", {27'b0, status}, 32'h4);

        // R8: clear with simultaneous overflow
        do_op(3'd0, 1'b0, 32'h7FFFFFFF, 32'h00000001, 1'b1);
        check(sticky == 2'b00, "R8", "clear beats set", {30'b0, sticky}, '0);
        check(status == 5'b00110, "R8", "status with clear", {27'b0, status}, 32'h6);
        check(result == 32'h80000000, "R8", "result with clear", result, 32'h80000000);

        // R6 / R7: non-overflow op does not set sticky, status is fresh
        do_op(3'd0, 1'b0, 32'h00000001, 32'h00000002, 1'b0);
        check(status == 5'b00000, "R6", "latest status", {27'b0, status}, '0);
        check(sticky == 2'b00, "R7", "no spurious set", {30'b0, sticky}, '0);

        do_op(3'd0, 1'b1, 32'h7FFFFFFF, 32'h00000001, 1'b0);
        check(sticky == 2'b01, "R7", "sticky set", {30'b0, sticky}, 32'd1);

        do_op(3'd3, 1'b0, 32'h00000001, 32'h00000001, 1'b0);
        check(status == 5'b00000, "R6", "ovf gone from status", {27'b0, status}, '0);
        check(sticky == 2'b01, "R7", "sticky persists", {30'b0, sticky}, 32'd1);
        check(result == 32'h00000001, "R2", "and result", result, 32'd1);

        // R9: reserved codes
        do_op(3'd6, 1'b1, 32'h80000000, 32'h80000000, 1'b0);
        check(result == 32'h00000001, "R9", "rsv6 result", result, 32'd1);
        check(status == 5'b00000, "R9", "rsv6 status", {27'b0, status}, '0);
        check(result_we == 1'b0, "R9", "rsv6 we", {31'b0, result_we}, '0);
        do_op(3'd7, 1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0);
        check(result == 32'h00000001, "R9", "rsv7 result", result, 32'd1);
        check(status == 5'b00000, "R9", "rsv7 status", {27'b0, status}, '0);
        check(sticky == 2'b01, "R9", "rsv7 sticky", {30'b0, sticky}, 32'd1);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule